// File: doc/BRIEF.md
# Address-Range Qualified Event Counter

This block counts retired load and retired store events, but only those whose address lies inside a programmed monitoring region. Software programs up to four coarse regions. Each one is a base word and a mask word, and an address matches a pair when every bit selected by the mask equals the same bit of the base. The coarse regions are therefore power-of-two sized and aligned. The monitored region is the union of every enabled pair, so a requested range can be covered by several smaller aligned blocks.

Qualification can use the data address or the instruction address of each event. When the instruction address is used, an exact fine window can replace the coarse pairs. This window has a start offset and an end offset inside one 4 KB page. Data addresses are always qualified through the coarse pairs.

Counting is controlled by a two-state run machine. `RUN_STOPPED` is the reset state. A control-register write with the run bit set moves it to `RUN_ACTIVE`. A control-register write with the run bit clear moves it back to `RUN_STOPPED`. Any other cycle keeps the current state. Events are counted only in `RUN_ACTIVE`. The two counters saturate and are cleared by a strobe.

Top module: `arq_event_counter`

## Requirements
- R1: After reset, both counters read zero, the run machine is in `RUN_STOPPED`, and every configuration register holds zero.
- R2: Coarse pair i (0..3) matches when `(addr & mask_i) == (base_i & mask_i)` and its enable bit is set. The region is the OR over all pairs. Selector layout: base words at selectors 0..3, mask words at 4..7, control at 8, fine window at 9, page at 10. All other selectors are ignored.
- R3: A pair whose enable bit is clear never matches. The enable bits sit in control bits [7:4], with bit 4+i belonging to pair i.
- R4: When control bit 1 (instruction space) and control bit 2 (fine) are both set, the coarse pairs are bypassed. An instruction address matches only when its bits [63:12] equal page-register bits [63:12] and `lo <= addr[11:0] < hi`. Here lo is fine-register bits [11:0] and hi is bits [27:16], so the end bound is exclusive.
- R5: With control bit 1 clear, the data address is qualified through the coarse pairs, whatever the value of the fine bit.
- R6: A qualified event with kind 2'b01 (load) adds one to the load counter. Kind 2'b10 (store) adds one to the store counter. Kinds 2'b00 and 2'b11 change neither counter, and neither does an event with the valid flag low.
- R7: Each counter stops at all-ones and holds there.
- R8: A clear strobe sets both counters to zero on the next edge. It takes priority over an event in the same cycle.
- R9: Control bit 0 is the run bit. While the machine is in `RUN_STOPPED`, the counters hold their values.
- R10: A register write takes effect on the edge that ends the write cycle. An event in that same cycle is qualified with the old register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | SEL_W (4) | Register selector |
| cfg_wr_data | input | ADDR_W (64) | Register write data |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event kind: 01 load, 10 store, others ignored |
| ev_daddr | input | ADDR_W | Data address of the event |
| ev_iaddr | input | ADDR_W | Instruction address of the event |
| load_count | output | CNT_W (32) | Qualified load count |
| store_count | output | CNT_W (32) | Qualified store count |

## Verification
The assertions assume that every input is a known value after reset and that a clear strobe is a plain level sampled at each edge. Under that assumption, a counter moves by at most one per cycle, and a single event can never move both counters at once. The random stimulus writes only the eleven defined selectors. It draws bases, addresses and page values from one small address window and masks as aligned power-of-two forms, so that matches and near misses both occur often. The fine window bounds are drawn freely, so empty and inverted windows also appear.

// File: rtl/arq_pkg.sv
package arq_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'b00,
        EV_LOAD  = 2'b01,
        EV_STORE = 2'b10,
        EV_OTHER = 2'b11
    } ev_kind_e;

    typedef enum logic {
        RUN_STOPPED = 1'b0,
        RUN_ACTIVE  = 1'b1
    } run_state_e;

    // control word fields
    localparam int CTRL_RUN      = 0;
    localparam int CTRL_ISPACE   = 1;
    localparam int CTRL_FINE     = 2;
    localparam int CTRL_PAIR_LSB = 4;

    // fine window word fields
    localparam int FINE_LO_LSB = 0;
    localparam int FINE_HI_LSB = 16;

endpackage

// File: rtl/arq_cfg_regs.sv
module arq_cfg_regs
    import arq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NPAIR    = 4,
    parameter int SEL_W    = 4,
    parameter int PAGE_LSB = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [ADDR_W-1:0]              wr_data,
    output logic [NPAIR-1:0][ADDR_W-1:0]   base_o,
    output logic [NPAIR-1:0][ADDR_W-1:0]   mask_o,
    output logic [NPAIR-1:0]               pair_en_o,
    output logic                           instr_space_o,
    output logic                           fine_o,
    output logic [PAGE_LSB-1:0]            fine_lo_o,
    output logic [PAGE_LSB-1:0]            fine_hi_o,
    output logic [ADDR_W-1:PAGE_LSB]       page_o,
    output logic                           run_o
);

    localparam int SEL_MASK0 = NPAIR;
    localparam int SEL_CTRL  = 2 * NPAIR;
    localparam int SEL_FINE  = SEL_CTRL + 1;
    localparam int SEL_PAGE  = SEL_CTRL + 2;

    logic [NPAIR-1:0][ADDR_W-1:0] base_q, mask_q;
    logic [NPAIR-1:0]             pair_en_q;
    logic                         ispace_q, fine_q;
    logic [PAGE_LSB-1:0]          lo_q, hi_q;
    logic [ADDR_W-1:PAGE_LSB]     page_q;
    logic                         wr_ctrl;

    run_state_e state_q, state_d;

    assign wr_ctrl = wr_en && (wr_sel == SEL_W'(SEL_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NPAIR; i++) begin
                if (wr_sel == SEL_W'(i))             base_q[i] <= wr_data;
                if (wr_sel == SEL_W'(SEL_MASK0 + i)) mask_q[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_en_q <= '0;
            ispace_q  <= 1'b0;
            fine_q    <= 1'b0;
            lo_q      <= '0;
            hi_q      <= '0;
            page_q    <= '0;
        end else if (wr_en) begin
            if (wr_ctrl) begin
                pair_en_q <= wr_data[CTRL_PAIR_LSB +: NPAIR];
                ispace_q  <= wr_data[CTRL_ISPACE];
                fine_q    <= wr_data[CTRL_FINE];
            end
            if (wr_sel == SEL_W'(SEL_FINE)) begin
                lo_q <= wr_data[FINE_LO_LSB +: PAGE_LSB];
                hi_q <= wr_data[FINE_HI_LSB +: PAGE_LSB];
            end
            if (wr_sel == SEL_W'(SEL_PAGE)) begin
                page_q <= wr_data[ADDR_W-1:PAGE_LSB];
            end
        end
    end

    // run machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_STOPPED: if (wr_ctrl && wr_data[CTRL_RUN])  state_d = RUN_ACTIVE;
            RUN_ACTIVE:  if (wr_ctrl && !wr_data[CTRL_RUN]) state_d = RUN_STOPPED;
            default:     state_d = RUN_STOPPED;
        endcase
    end

    // run machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_STOPPED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run_o         = (state_q == RUN_ACTIVE);
        base_o        = base_q;
        mask_o        = mask_q;
        pair_en_o     = pair_en_q;
        instr_space_o = ispace_q;
        fine_o        = fine_q;
        fine_lo_o     = lo_q;
        fine_hi_o     = hi_q;
        page_o        = page_q;
    end

    assert_ctrl_takes_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (run_o == $past(wr_data[CTRL_RUN])))
        else $error("run bit not applied one edge after control write");

    assert_run_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(run_o))
        else $error("run state moved without a control write");

endmodule

// File: rtl/arq_coarse_match.sv
module arq_coarse_match #(
    parameter int ADDR_W = 64,
    parameter int NPAIR  = 4
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NPAIR-1:0][ADDR_W-1:0]  base_i,
    input  logic [NPAIR-1:0][ADDR_W-1:0]  mask_i,
    input  logic [NPAIR-1:0]              pair_en_i,
    output logic [NPAIR-1:0]              pair_hit_o,
    output logic                          any_hit_o
);

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair_hit_o[g] = pair_en_i[g] &&
                               ((addr_i & mask_i[g]) == (base_i[g] & mask_i[g]));
    end

    assign any_hit_o = |pair_hit_o;

endmodule

// File: rtl/arq_fine_match.sv
module arq_fine_match #(
    parameter int ADDR_W   = 64,
    parameter int PAGE_LSB = 12
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [ADDR_W-1:PAGE_LSB] page_i,
    input  logic [PAGE_LSB-1:0]      lo_i,
    input  logic [PAGE_LSB-1:0]      hi_i,
    output logic                     hit_o
);

    logic                same_page;
    logic [PAGE_LSB-1:0] ofs;

    assign same_page = (addr_i[ADDR_W-1:PAGE_LSB] == page_i);
    assign ofs       = addr_i[PAGE_LSB-1:0];
    assign hit_o     = same_page && (ofs >= lo_i) && (ofs < hi_i);

endmodule

// File: rtl/arq_sat_counter.sv
module arq_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clr_i)                      cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0))
        else $error("counter not zero after clear");

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX))
        else $error("counter left saturation");

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1)))
        else $error("counter moved by more than one");

endmodule

// File: rtl/arq_event_counter.sv
module arq_event_counter
    import arq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CNT_W    = 32,
    parameter int NPAIR    = 4,
    parameter int PAGE_LSB = 12,
    localparam int SEL_W   = $clog2(2 * NPAIR + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              cnt_clear,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_daddr,
    input  logic [ADDR_W-1:0] ev_iaddr,
    output logic [CNT_W-1:0]  load_count,
    output logic [CNT_W-1:0]  store_count
);

    logic [NPAIR-1:0][ADDR_W-1:0] base, mask;
    logic [NPAIR-1:0]             pair_en, pair_hit;
    logic                         instr_space, fine, run;
    logic [PAGE_LSB-1:0]          fine_lo, fine_hi;
    logic [ADDR_W-1:PAGE_LSB]     page;
    logic [ADDR_W-1:0]            qual_addr;
    logic                         coarse_hit, fine_hit, fine_active, region_hit;
    logic                         count_ok, load_inc, store_inc;
    ev_kind_e                     kind;

    arq_cfg_regs #(
        .ADDR_W(ADDR_W), .NPAIR(NPAIR), .SEL_W(SEL_W), .PAGE_LSB(PAGE_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
        .base_o(base), .mask_o(mask), .pair_en_o(pair_en),
        .instr_space_o(instr_space), .fine_o(fine),
        .fine_lo_o(fine_lo), .fine_hi_o(fine_hi), .page_o(page),
        .run_o(run)
    );

    assign qual_addr = instr_space ? ev_iaddr : ev_daddr;

    arq_coarse_match #(.ADDR_W(ADDR_W), .NPAIR(NPAIR)) u_coarse (
        .addr_i(qual_addr), .base_i(base), .mask_i(mask), .pair_en_i(pair_en),
        .pair_hit_o(pair_hit), .any_hit_o(coarse_hit)
    );

    arq_fine_match #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_fine (
        .addr_i(qual_addr), .page_i(page), .lo_i(fine_lo), .hi_i(fine_hi),
        .hit_o(fine_hit)
    );

    // fine window only applies to instruction addresses
    assign fine_active = instr_space && fine;
    assign region_hit  = fine_active ? fine_hit : coarse_hit;

    assign kind      = ev_kind_e'(ev_kind);
    assign count_ok  = run && ev_valid && region_hit;
    assign load_inc  = count_ok && (kind == EV_LOAD);
    assign store_inc = count_ok && (kind == EV_STORE);

    arq_sat_counter #(.CNT_W(CNT_W)) u_load_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clear), .inc_i(load_inc), .cnt_o(load_count)
    );

    arq_sat_counter #(.CNT_W(CNT_W)) u_store_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clear), .inc_i(store_inc), .cnt_o(store_count)
    );

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clear) |=> ($stable(load_count) && $stable(store_count)))
        else $error("counter moved while stopped");

    assert_one_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> !((load_count != $past(load_count)) && (store_count != $past(store_count))))
        else $error("one event moved both counters");

    assert_disabled_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en == '0 && !fine_active) |-> !region_hit)
        else $error("region hit with every pair disabled");

    assert_page_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_active && region_hit) |-> (qual_addr[ADDR_W-1:PAGE_LSB] == page))
        else $error("fine hit outside the programmed page");

endmodule

// File: tb/tb_arq_event_counter.sv
`timescale 1ns/1ps
module tb_arq_event_counter;

    localparam int AW = 64;
    localparam int CW = 8;
    localparam int NP = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [SW-1:0] cfg_wr_sel = '0;
    logic [AW-1:0] cfg_wr_data = '0;
    logic          cnt_clear = 1'b0;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_kind = 2'b00;
    logic [AW-1:0] ev_daddr = '0;
    logic [AW-1:0] ev_iaddr = '0;
    logic [CW-1:0] load_count, store_count;

    always #2 clk = ~clk;

    arq_event_counter #(.ADDR_W(AW), .CNT_W(CW), .NPAIR(NP)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cnt_clear(cnt_clear), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_daddr(ev_daddr), .ev_iaddr(ev_iaddr),
        .load_count(load_count), .store_count(store_count)
    );

    // reference state
    logic [AW-1:0] mb [NP];
    logic [AW-1:0] mm [NP];
    logic [AW-1:0] mctl, mfine, mpage;
    logic [CW-1:0] eload, estore;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [1:0] K_LOAD = 2'b01, K_STORE = 2'b10;

    function automatic logic model_hit(input logic [AW-1:0] da, input logic [AW-1:0] ia);
        logic [AW-1:0] a;
        logic h;
        a = mctl[1] ? ia : da;
        h = 1'b0;
        if (mctl[1] && mctl[2])
            h = (a[63:12] == mpage[63:12]) && (a[11:0] >= mfine[11:0]) && (a[11:0] < mfine[27:16]);
        else
            for (int i = 0; i < NP; i++)
                if (mctl[4+i] && ((a & mm[i]) == (mb[i] & mm[i]))) h = 1'b1;
        return h;
    endfunction

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
        return (x == '1) ? x : x + 1'b1;
    endfunction

    task automatic cyc(input logic we, input int sel, input logic [AW-1:0] wd,
                       input logic v, input logic [1:0] k,
                       input logic [AW-1:0] da, input logic [AW-1:0] ia, input logic clr);
        cfg_wr_en = we; cfg_wr_sel = SW'(sel); cfg_wr_data = wd;
        ev_valid = v; ev_kind = k; ev_daddr = da; ev_iaddr = ia; cnt_clear = clr;
        if (clr) begin
            eload = '0; estore = '0;
        end else if (mctl[0] && v && model_hit(da, ia)) begin
            if (k == K_LOAD)  eload  = sat_inc(eload);
            if (k == K_STORE) estore = sat_inc(estore);
        end
        if (we) begin
            if (sel < 4)       mb[sel] = wd;
            else if (sel < 8)  mm[sel-4] = wd;
            else if (sel == 8) mctl = wd;
            else if (sel == 9) mfine = wd;
            else if (sel == 10) mpage = wd;
        end
        @(negedge clk);
        cfg_wr_en = 1'b0; ev_valid = 1'b0; cnt_clear = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [AW-1:0] d);
        cyc(1'b1, sel, d, 1'b0, 2'b00, '0, '0, 1'b0);
    endtask

    task automatic ev(input logic [1:0] k, input logic [AW-1:0] da, input logic [AW-1:0] ia);
        cyc(1'b0, 0, '0, 1'b1, k, da, ia, 1'b0);
    endtask

    task automatic check_model(input string tag);
        tests++;
        if (load_count !== eload || store_count !== estore) begin
            fails++;
            $display("FAIL %s load=%0d exp %0d store=%0d exp %0d", tag, load_count, eload, store_count, estore);
        end
    endtask

    task automatic check_lit(input string tag, input logic [CW-1:0] ld, input logic [CW-1:0] st);
        tests++;
        if (load_count !== ld || store_count !== st) begin
            fails++;
            $display("FAIL %s load=%0d exp %0d store=%0d exp %0d", tag, load_count, ld, store_count, st);
        end
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        return {32'h0, 16'h1000, 16'($urandom)};
    endfunction

    function automatic logic [AW-1:0] rnd_data(input int sel);
        int k;
        if (sel < 4 || sel == 10) return rnd_addr();
        if (sel < 8) begin
            k = 2 + int'($urandom % 13);
            return ~((64'd1 << k) - 64'd1);
        end
        if (sel == 8) return {56'h0, 8'($urandom) & 8'hF6} | (($urandom % 4 != 0) ? 64'd1 : 64'd0);
        return {36'h0, 12'($urandom), 4'h0, 12'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin mb[i] = '0; mm[i] = '0; end
        mctl = '0; mfine = '0; mpage = '0; eload = '0; estore = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_lit("R1 reset", 8'd0, 8'd0);
        ev(K_LOAD, 64'h0, 64'h0);       // zero regs, stopped
        check_lit("R1 stopped after reset", 8'd0, 8'd0);

        // R2: single coarse pair, 4 KB block
        wr(0, 64'h1000_0000);
        wr(4, ~64'hFFF);
        wr(8, 64'h11);
        ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R2 inside pair0", 8'd1, 8'd0);
        ev(K_LOAD, 64'h1000_1000, 64'h0);
        check_lit("R2 just past pair0", 8'd1, 8'd0);
        // R2: union with pair1
        wr(1, 64'h2000_0000);
        wr(5, ~64'hFF);
        wr(8, 64'h31);
        ev(K_STORE, 64'h2000_00FF, 64'h0);
        check_lit("R2 union pair1", 8'd1, 8'd1);
        ev(K_STORE, 64'h1000_0004, 64'h0);
        check_lit("R2 union pair0", 8'd1, 8'd2);

        // R3: pair0 disabled
        wr(8, 64'h21);
        ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R3 disabled pair", 8'd1, 8'd2);

        // R10: write and event in same cycle use old enables
        cyc(1'b1, 8, 64'h11, 1'b1, K_LOAD, 64'h1000_0800, 64'h0, 1'b0);
        check_lit("R10 same cycle old value", 8'd1, 8'd2);
        ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R10 next cycle new value", 8'd2, 8'd2);

        // R6: other kinds and invalid
        ev(2'b00, 64'h1000_0800, 64'h0);
        ev(2'b11, 64'h1000_0800, 64'h0);
        cyc(1'b0, 0, '0, 1'b0, K_LOAD, 64'h1000_0800, 64'h0, 1'b0);
        check_lit("R6 ignored kinds", 8'd2, 8'd2);

        // R9: stopped
        wr(8, 64'h10);
        ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R9 stopped holds", 8'd2, 8'd2);

        // R5: data space ignores fine bit
        wr(8, 64'h15);
        ev(K_LOAD, 64'h1000_0800, 64'hFFFF_0000);
        check_lit("R5 data space coarse", 8'd3, 8'd2);

        // R4: fine window 0x100..0x1FF on page 0x4000_0000_0000_3000
        wr(9, 64'h0200_0100);
        wr(10, 64'h4000_0000_0000_3000);
        wr(8, 64'h07);
        ev(K_LOAD, 64'h1000_0800, 64'h4000_0000_0000_3100);
        check_lit("R4 fine low bound", 8'd4, 8'd2);
        ev(K_LOAD, 64'h1000_0800, 64'h4000_0000_0000_31FF);
        check_lit("R4 fine last byte", 8'd5, 8'd2);
        ev(K_LOAD, 64'h1000_0800, 64'h4000_0000_0000_3200);
        check_lit("R4 fine exclusive end", 8'd5, 8'd2);
        ev(K_LOAD, 64'h1000_0800, 64'h4000_0000_0000_30FF);
        check_lit("R4 fine below start", 8'd5, 8'd2);
        ev(K_LOAD, 64'h1000_0800, 64'h4000_0000_0000_4100);
        check_lit("R4 fine other page", 8'd5, 8'd2);
        // instruction space, coarse
        wr(8, 64'h13);
        ev(K_STORE, 64'h0, 64'h1000_0010);
        check_lit("R2 instr coarse hit", 8'd5, 8'd3);
        ev(K_STORE, 64'h1000_0010, 64'h0);
        check_lit("R2 instr coarse ignores data addr", 8'd5, 8'd3);

        // R8: clear beats event
        wr(8, 64'h11);
        cyc(1'b0, 0, '0, 1'b1, K_LOAD, 64'h1000_0800, 64'h0, 1'b1);
        check_lit("R8 clear priority", 8'd0, 8'd0);
        ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R8 count after clear", 8'd1, 8'd0);

        // R7: saturation
        for (int n = 0; n < 300; n++) ev(K_LOAD, 64'h1000_0800, 64'h0);
        check_lit("R7 saturate", 8'hFF, 8'd0);
        cyc(1'b0, 0, '0, 1'b0, 2'b00, '0, '0, 1'b1);
        check_lit("R8 clear from saturation", 8'd0, 8'd0);

        // random phase
        for (int n = 0; n < 5000; n++) begin
            int r;
            int sel;
            logic [AW-1:0] a, ia;
            r = int'($urandom % 16);
            a = rnd_addr();
            ia = rnd_addr();
            if (r == 0) begin
                sel = int'($urandom % 11);
                cyc(1'b1, sel, rnd_data(sel), $urandom % 2 == 0, 2'($urandom), a, ia, 1'b0);
            end else if (r == 1) begin
                cyc(1'b0, 0, '0, 1'b1, 2'($urandom), a, ia, 1'b1);
            end else begin
                cyc(1'b0, 0, '0, $urandom % 8 != 0, 2'($urandom), a, ia, 1'b0);
            end
            check_model("R6 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule